// File: doc/BRIEF.md
# Cascadable Presettable Counter Slice

This block is a small synchronous up-counter, one digit wide, that can be preloaded, cleared and chained. Two compile-time switches configure it. One sets the modulus: a BCD digit that wraps after 9, or a plain binary nibble that wraps after 15. The other sets the clear: asynchronous, acting at once, or synchronous, acting at the next rising clock edge. All other state changes happen on the rising edge of `clk`.

Two enables gate counting. `en_p` is the parallel enable and `en_t` is the trickle enable. The `carry` output flags the terminal count and is gated by `en_t` only. To build a wider counter, tie every slice's `en_p` together and feed each slice's `carry` into the `en_t` of the next slice up. No extra gates are needed. All pins are plain control and data levels. No data stream crosses the boundary, so there is no valid/ready handshake and no back-pressure.

Top module: `cnt_slice`

## Requirements
- R1: Apart from an asynchronous clear, `q` changes only at a rising edge of `clk`. Input changes between edges leave `q` unchanged.
- R2: With `ASYNC_CLR`=1, driving `clr_n` low forces `q` to 0 at once, with no clock edge.
- R3: With `ASYNC_CLR`=0, driving `clr_n` low leaves `q` unchanged until the next rising edge, which sets `q` to 0.
- R4: Clear has top priority. While `clr_n` is low, the load and enable inputs have no effect and `q` is 0 after the edge.
- R5: When `clr_n` is high and `load_n` is low, the edge loads `din` into `q`. Load wins over counting and works whatever the enables are.
- R6: When `clr_n` and `load_n` are both high, `q` advances by one only if `en_p` and `en_t` are both high. In every other case it holds.
- R7: With `DECADE`=1, counting runs 0,1,…,9,0. With `DECADE`=0 it runs 0,1,…,15,0.
- R8: With `DECADE`=1, a loaded value from 10 to 15 counts up by one per enabled edge, and 15 is followed by 0.
- R9: `carry` is high exactly when `q` equals the terminal value and `en_t` is high. The terminal value is 9 when `DECADE`=1 and 15 when `DECADE`=0. `en_p` has no effect on `carry`.
- R10: Two slices chained as follows count as one two-digit counter that wraps from 99 to 00 (decade) or from 255 to 0 (binary). The low slice's `carry` drives the high slice's `en_t`, and the two slices share `en_p`, `clk`, `clr_n` and `load_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| clr_n | input | 1 | Clear, active low; asynchronous or synchronous per `ASYNC_CLR` |
| load_n | input | 1 | Parallel load, active low, taken at the rising edge |
| din | input | WIDTH | Value to load |
| en_p | input | 1 | Parallel count enable |
| en_t | input | 1 | Trickle count enable; also gates `carry` |
| q | output | WIDTH | Current count |
| carry | output | 1 | Terminal count while `en_t` is high |

## Verification
The bench builds two chains of two slices each, with `WIDTH`=4. The first chain uses `DECADE`=1 and `ASYNC_CLR`=1, and the second uses `DECADE`=0 and `ASYNC_CLR`=0. Both chains receive the same stimulus. This setup places the immediate clear and the edge-timed clear side by side in one cycle. It also shows one load value giving an out-of-range BCD digit in one chain and an ordinary binary value in the other. A long enabled run covers the two-digit decade wrap, and loading 8'hFF covers the binary chain's full carry.

// File: rtl/cnt_slice_pkg.sv
package cnt_slice_pkg;

  // Operation selected for the next rising edge, in priority order.
  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_COUNT = 2'd1,
    OP_LOAD  = 2'd2,
    OP_CLEAR = 2'd3
  } cnt_op_e;

  // Last value before wrap: 9 for a BCD digit, all ones for binary.
  function automatic logic [31:0] term_of(input bit decade, input int width);
    return decade ? 32'd9 : ((32'd1 << width) - 32'd1);
  endfunction

endpackage

// File: rtl/cnt_ctrl.sv
module cnt_ctrl
  import cnt_slice_pkg::*;
(
  input  logic    clr_n,
  input  logic    load_n,
  input  logic    en_p,
  input  logic    en_t,
  output cnt_op_e op
);

  // Fixed priority: clear, then load, then count, else hold.
  always_comb begin
    if (!clr_n)
      op = OP_CLEAR;
    else if (!load_n)
      op = OP_LOAD;
    else if (en_p && en_t)
      op = OP_COUNT;
    else
      op = OP_HOLD;
  end

endmodule

// File: rtl/cnt_next.sv
module cnt_next
  import cnt_slice_pkg::*;
#(
  parameter int               WIDTH  = 4,
  parameter logic [WIDTH-1:0] TERM_V = '1
) (
  input  cnt_op_e          op,
  input  logic [WIDTH-1:0] q,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] nxt,
  output logic             at_term
);

  logic [WIDTH-1:0] inc;

  assign at_term = (q == TERM_V);

  // Terminal value wraps to zero; anything else (including out-of-range
  // values above the terminal) takes a plain modulo-2^WIDTH increment.
  assign inc = at_term ? '0 : q + {{(WIDTH-1){1'b0}}, 1'b1};

  always_comb begin
    unique case (op)
      OP_CLEAR: nxt = '0;
      OP_LOAD:  nxt = din;
      OP_COUNT: nxt = inc;
      default:  nxt = q;
    endcase
  end

endmodule

// File: rtl/cnt_reg.sv
module cnt_reg #(
  parameter int WIDTH     = 4,
  parameter bit ASYNC_CLR = 1'b1
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic [WIDTH-1:0] nxt,
  output logic [WIDTH-1:0] q
);

  generate
    if (ASYNC_CLR) begin : g_async
      always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n)
          q <= '0;
        else
          q <= nxt;
      end
    end else begin : g_sync
      // nxt is already zero when clear is sampled low
      always_ff @(posedge clk) begin
        q <= nxt;
      end
    end
  endgenerate

  // R4
  clr_release_chk: assert property (@(posedge clk) disable iff (!clr_n)
    $rose(clr_n) |-> (q == '0));

endmodule

// File: rtl/cnt_slice.sv
module cnt_slice
  import cnt_slice_pkg::*;
#(
  parameter int WIDTH     = 4,
  parameter bit DECADE    = 1'b0,
  parameter bit ASYNC_CLR = 1'b1
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic             load_n,
  input  logic [WIDTH-1:0] din,
  input  logic             en_p,
  input  logic             en_t,
  output logic [WIDTH-1:0] q,
  output logic             carry
);

  localparam logic [WIDTH-1:0] TERM_V = WIDTH'(term_of(DECADE, WIDTH));

  cnt_op_e          op;
  logic [WIDTH-1:0] nxt;
  logic             at_term;

  cnt_ctrl u_ctrl (
    .clr_n  (clr_n),
    .load_n (load_n),
    .en_p   (en_p),
    .en_t   (en_t),
    .op     (op)
  );

  cnt_next #(.WIDTH(WIDTH), .TERM_V(TERM_V)) u_next (
    .op      (op),
    .q       (q),
    .din     (din),
    .nxt     (nxt),
    .at_term (at_term)
  );

  cnt_reg #(.WIDTH(WIDTH), .ASYNC_CLR(ASYNC_CLR)) u_reg (
    .clk   (clk),
    .clr_n (clr_n),
    .nxt   (nxt),
    .q     (q)
  );

  // Carry for the next slice: terminal count qualified by trickle enable only
  assign carry = at_term & en_t;

  // R5
  load_take_chk: assert property (@(posedge clk) disable iff (!clr_n)
    (clr_n && !load_n) |=> (q == $past(din)));

  // R6
  hold_chk: assert property (@(posedge clk) disable iff (!clr_n)
    (clr_n && load_n && !(en_p && en_t)) |=> $stable(q));

  // R7
  step_chk: assert property (@(posedge clk) disable iff (!clr_n)
    (clr_n && load_n && en_p && en_t && (q != TERM_V)) |=> (q == WIDTH'($past(q) + 1'b1)));

  // R7
  wrap_chk: assert property (@(posedge clk) disable iff (!clr_n)
    (clr_n && load_n && en_p && en_t && (q == TERM_V)) |=> (q == '0));

  // R9
  carry_gate_chk: assert property (@(posedge clk) disable iff (!clr_n)
    !en_t |-> !carry);

endmodule

// File: tb/cnt_slice_tb_top.sv
`timescale 1ns/1ps
module cnt_slice_tb_top;

  logic       clk = 1'b0;
  logic       clr_n = 1'b0;
  logic       load_n = 1'b1;
  logic [7:0] din = 8'h00;
  logic       en_p = 1'b0;
  logic       en_t = 1'b0;

  logic [3:0] dq_lo, dq_hi, bq_lo, bq_hi;
  logic       dc_lo, dc_hi, bc_lo, bc_hi;

  always #2 clk = ~clk;

  // Decade chain, asynchronous clear
  cnt_slice #(.WIDTH(4), .DECADE(1'b1), .ASYNC_CLR(1'b1)) dut_i (
    .clk(clk), .clr_n(clr_n), .load_n(load_n), .din(din[3:0]),
    .en_p(en_p), .en_t(en_t), .q(dq_lo), .carry(dc_lo));
  cnt_slice #(.WIDTH(4), .DECADE(1'b1), .ASYNC_CLR(1'b1)) dec_hi_i (
    .clk(clk), .clr_n(clr_n), .load_n(load_n), .din(din[7:4]),
    .en_p(en_p), .en_t(dc_lo), .q(dq_hi), .carry(dc_hi));

  // Binary chain, synchronous clear
  cnt_slice #(.WIDTH(4), .DECADE(1'b0), .ASYNC_CLR(1'b0)) bin_lo_i (
    .clk(clk), .clr_n(clr_n), .load_n(load_n), .din(din[3:0]),
    .en_p(en_p), .en_t(en_t), .q(bq_lo), .carry(bc_lo));
  cnt_slice #(.WIDTH(4), .DECADE(1'b0), .ASYNC_CLR(1'b0)) bin_hi_i (
    .clk(clk), .clr_n(clr_n), .load_n(load_n), .din(din[7:4]),
    .en_p(en_p), .en_t(bc_lo), .q(bq_hi), .carry(bc_hi));

  typedef struct {
    logic [7:0] qa;
    logic       ca;
    logic [7:0] qb;
    logic       cb;
    string      tag;
  } exp_t;

  exp_t exp_q[$];
  exp_t cur;

  int n_cmp = 0;
  int n_bad = 0;

  // reference state
  logic [3:0] ra_lo = 4'd0, ra_hi = 4'd0, rb_lo = 4'd0, rb_hi = 4'd0;

  function automatic logic [3:0] nx(input logic [3:0] v, input logic [3:0] term);
    return (v == term) ? 4'd0 : v + 4'd1;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [8:0] act, input logic [8:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual {carry,q}=%h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // Driver: apply one cycle of stimulus and push the expected post-edge result
  task automatic step(input logic c, input logic l, input logic [7:0] d,
                      input logic ep, input logic et, input string tag);
    logic la, lb;
    @(negedge clk);
    clr_n = c; load_n = l; din = d; en_p = ep; en_t = et;
    #1;
    if (!c) begin
      // R2: decade chain clears immediately; R3: binary chain waits for edge
      check({dq_hi, dq_lo} == 8'h00, "R2 immediate clear", {1'b0, dq_hi, dq_lo}, 9'h000);
      check({bq_hi, bq_lo} == {rb_hi, rb_lo}, "R3 clear waits for edge",
            {1'b0, bq_hi, bq_lo}, {1'b0, rb_hi, rb_lo});
    end else begin
      // R1: no change between edges
      check({dq_hi, dq_lo} == {ra_hi, ra_lo}, "R1 decade stable mid-cycle",
            {1'b0, dq_hi, dq_lo}, {1'b0, ra_hi, ra_lo});
      check({bq_hi, bq_lo} == {rb_hi, rb_lo}, "R1 binary stable mid-cycle",
            {1'b0, bq_hi, bq_lo}, {1'b0, rb_hi, rb_lo});
    end
    if (!c) begin
      ra_lo = 0; ra_hi = 0; rb_lo = 0; rb_hi = 0;
    end else if (!l) begin
      ra_lo = d[3:0]; ra_hi = d[7:4]; rb_lo = d[3:0]; rb_hi = d[7:4];
    end else begin
      la = (ra_lo == 4'd9) && et;
      lb = (rb_lo == 4'd15) && et;
      if (ep && et) begin ra_lo = nx(ra_lo, 4'd9); rb_lo = nx(rb_lo, 4'd15); end
      if (ep && la) ra_hi = nx(ra_hi, 4'd9);
      if (ep && lb) rb_hi = nx(rb_hi, 4'd15);
    end
    cur.qa  = {ra_hi, ra_lo};
    cur.ca  = (ra_hi == 4'd9) && (ra_lo == 4'd9) && et;
    cur.qb  = {rb_hi, rb_lo};
    cur.cb  = (rb_hi == 4'd15) && (rb_lo == 4'd15) && et;
    cur.tag = tag;
    exp_q.push_back(cur);
  endtask

  // Monitor: compare after each edge against the oldest expected item
  exp_t got;
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      got = exp_q.pop_front();
      check({dc_hi, dq_hi, dq_lo} == {got.ca, got.qa}, {got.tag, " decade chain"},
            {dc_hi, dq_hi, dq_lo}, {got.ca, got.qa});
      check({bc_hi, bq_hi, bq_lo} == {got.cb, got.qb}, {got.tag, " binary chain"},
            {bc_hi, bq_hi, bq_lo}, {got.cb, got.qb});
    end
  end

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(20000 * 4);
    n_bad++;
    $display("FAIL watchdog expired at %0t", $time);
    finish_run();
  end

  initial begin
    // R4: reset state under clear, with load and enables active
    step(1'b0, 1'b0, 8'h37, 1'b1, 1'b1, "R4 clear beats load");
    step(1'b0, 1'b1, 8'h00, 1'b1, 1'b1, "R4 clear beats count");
    // R7 / R10: long enabled run, decade wraps 99->00
    for (int i = 0; i < 120; i++) step(1'b1, 1'b1, 8'h00, 1'b1, 1'b1, "R7 R10 count run");
    // R5: load with enables low
    step(1'b1, 1'b0, 8'h42, 1'b0, 1'b0, "R5 load with enables low");
    // R6: hold with one enable low each way
    step(1'b1, 1'b1, 8'h00, 1'b0, 1'b1, "R6 hold en_p low");
    step(1'b1, 1'b1, 8'h00, 1'b1, 1'b0, "R6 hold en_t low");
    step(1'b1, 1'b1, 8'h00, 1'b0, 1'b0, "R6 hold both low");
    // R8: out-of-range BCD digits count up and wrap 15->0
    step(1'b1, 1'b0, 8'hF5, 1'b0, 1'b0, "R8 load F5");
    for (int i = 0; i < 14; i++) step(1'b1, 1'b1, 8'h00, 1'b1, 1'b1, "R8 out-of-range high digit");
    step(1'b1, 1'b0, 8'h3C, 1'b1, 1'b1, "R8 load 3C");
    for (int i = 0; i < 6; i++) step(1'b1, 1'b1, 8'h00, 1'b1, 1'b1, "R8 out-of-range low digit");
    // R9: carry at terminal, gated by en_t, not en_p
    step(1'b1, 1'b0, 8'h99, 1'b0, 1'b1, "R9 load 99 carry");
    step(1'b1, 1'b1, 8'h00, 1'b0, 1'b1, "R9 carry with en_p low");
    step(1'b1, 1'b1, 8'h00, 1'b0, 1'b0, "R9 carry gated by en_t");
    step(1'b1, 1'b0, 8'hFF, 1'b0, 1'b1, "R9 load FF carry");
    step(1'b1, 1'b1, 8'h00, 1'b1, 1'b1, "R10 binary wrap FF->00");
    step(1'b1, 1'b0, 8'hFE, 1'b1, 1'b1, "R5 load over count");
    step(1'b1, 1'b1, 8'h00, 1'b1, 1'b1, "R10 binary to FF");
    // R2 / R3: clear after counting
    step(1'b0, 1'b1, 8'h00, 1'b1, 1'b1, "R2 R3 clear after count");
    step(1'b1, 1'b1, 8'h00, 1'b1, 1'b1, "R6 count after clear");
    @(negedge clk);
    @(negedge clk);
    finish_run();
  end

endmodule